// File: doc/BRIEF.md
# Lockable Translation-Service Register Bank

This block is the control register file of an interrupt translation service. Software reaches it through a simple request/response port that carries an address, an access size in bytes, write data and read data. The bank holds a control word, a constant identification word, a constant capability word, a command-queue base, a pair of command-queue offsets (producer and consumer), and a row of table base registers. Every register except the control and identification words accepts both 64-bit accesses and 32-bit accesses to either half.

The bank drives the configuration outputs that a command-queue processor needs. It also sends that processor a one-cycle kick whenever software advances the producer offset away from the consumer offset. Setting the enable bit locks the queue base and the table bases. A bus-level security-disable input decides whether software may move the consumer offset. An access of an unsupported size, or to an unmapped offset, completes normally: a read of it returns zero and a write to it is dropped.

Top module: `xlat_regbank`

## Requirements
- R1: After reset the control word (offset 0x00, 4-byte) reads 0x8000_0000, with the quiescent bit 31 set and the enable bit 0 clear. Table base 0 (offset 0x40) reads 0x010F_0000_0000_0200: type field [58:56] is 1, entry-size-minus-one field [52:48] is 15, and page-size field [9:8] is 2, meaning 64 KB. Table base 1 (offset 0x48) reads 0x040F_0000_0000_0200, which has type 4. The remaining table bases, the queue base and both offsets read 0.
- R2: A write to the control word ORs the write data into the stored value, so no bit can be cleared by a write. `cfg_en` follows bit 0.
- R3: While enabled, writes to the queue base (0x10) and to every table base (0x40 + 8*i) are ignored.
- R4: Any accepted write to the queue base, of either width and to either half, clears the producer offset (0x18) and the consumer offset (0x20) to 0.
- R5: A write to the producer offset stores the data with bit 0 (retry) forced to 0. `proc_kick` pulses for one cycle when the write is full-width or to the low half and the new value differs from the consumer offset. A write to the upper half never kicks.
- R6: A write to the consumer offset takes effect only while `sec_dis` is 1, and it stores the data with bit 0 (stalled) forced to 0. While `sec_dis` is 0 the write is ignored.
- R7: Table base fields [58:56] and [52:48] are read-only. A 4-byte write changes only the addressed half: offset +0 selects bits 31:0 and offset +4 selects bits 63:32.
- R8: Only sizes 4 (4-byte aligned) and 8 (8-byte aligned) are valid. The control and identification words accept size 4 only. Any other access reads 0, drops its write, and still gets a response.
- R9: The capability word (0x08) and the identification word (0x04) return their parameter values and ignore writes.
- R10: Every request receives `rsp_valid` on the following cycle. A read returns the register value as it stood before that clock edge, zero-extended for 4-byte reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the bank |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data; a 4-byte access uses bits 31:0 |
| sec_dis | input | 1 | Security disable; allows consumer-offset writes |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data; 0 for writes and invalid accesses |
| cfg_en | output | 1 | Enable bit of the control word |
| cfg_qbase | output | 64 | Command-queue base |
| cfg_wroff | output | 64 | Producer offset |
| cfg_rdoff | output | 64 | Consumer offset |
| cfg_tbase | output | NTAB*64 | Table bases; entry i is bits 64*i+63 : 64*i |
| proc_kick | output | 1 | One-cycle request for the queue processor |

## Verification
Register updates, `rsp_valid`, `rsp_rdata` and `proc_kick` all come from the edge that samples the request, so each result is due exactly one cycle after the request. The bench drives each request at a falling edge and records the expected response and kick in a queue. A monitor process compares them at the next falling edge, after the register has settled. Each effect of a write is checked by a later read through the same port, so every response is compared exactly one cycle after its request and no cycle needs a separate timing allowance.

// File: rtl/xrb_pkg.sv
package xrb_pkg;

  localparam int unsigned OFF_CTRL  = 'h00;
  localparam int unsigned OFF_IDENT = 'h04;
  localparam int unsigned OFF_TYPE  = 'h08;
  localparam int unsigned OFF_QBASE = 'h10;
  localparam int unsigned OFF_WROFF = 'h18;
  localparam int unsigned OFF_RDOFF = 'h20;
  localparam int unsigned OFF_TBASE = 'h40;

  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_QUIET_BIT = 31;

  localparam logic [63:0] TB_RO_MASK = 64'h071F_0000_0000_0000;
  localparam logic [63:0] LOW_FLAG   = 64'h1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_IDENT, SEL_TYPE,
    SEL_QBASE, SEL_WROFF, SEL_RDOFF, SEL_TBASE
  } sel_e;

  typedef enum logic [1:0] {
    LANE_FULL, LANE_LO, LANE_HI
  } lane_e;

  function automatic logic [63:0] lane_merge(input logic [63:0] old,
                                             input logic [63:0] wd,
                                             input lane_e lane);
    logic [63:0] r;
    case (lane)
      LANE_LO: r = {old[63:32], wd[31:0]};
      LANE_HI: r = {wd[31:0], old[31:0]};
      default: r = wd;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] lane_read(input logic [63:0] v,
                                            input lane_e lane);
    logic [63:0] r;
    case (lane)
      LANE_LO: r = {32'h0, v[31:0]};
      LANE_HI: r = {32'h0, v[63:32]};
      default: r = v;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] tb_merge(input logic [63:0] old,
                                           input logic [63:0] wd,
                                           input lane_e lane);
    logic [63:0] m;
    m = lane_merge(old, wd, lane);
    return (m & ~TB_RO_MASK) | (old & TB_RO_MASK);
  endfunction

  function automatic logic [63:0] tb_reset(input int idx);
    logic [63:0] v;
    v = '0;
    if (idx == 0 || idx == 1) begin
      v[58:56] = (idx == 0) ? 3'd1 : 3'd4;
      v[52:48] = 5'd15;
      v[9:8]   = 2'd2;
    end
    return v;
  endfunction

endpackage

// File: rtl/xrb_decode.sv
module xrb_decode
  import xrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NTAB   = 8,
  localparam int IDX_W = (NTAB > 1) ? $clog2(NTAB) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output sel_e              sel,
  output lane_e             lane,
  output logic [IDX_W-1:0]  tidx
);
  logic              is_full;
  logic              is_half;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] rel;
  logic              in_tab;

  assign is_full = (size == 4'd8) && (addr[2:0] == 3'b000);
  assign is_half = (size == 4'd4) && (addr[1:0] == 2'b00);
  assign base    = {addr[ADDR_W-1:3], 3'b000};
  assign rel     = base - ADDR_W'(OFF_TBASE);
  assign in_tab  = (base >= ADDR_W'(OFF_TBASE)) && (rel < ADDR_W'(NTAB * 8));
  assign tidx    = rel[IDX_W+2:3];

  always_comb begin
    sel  = SEL_NONE;
    lane = is_full ? LANE_FULL : (addr[2] ? LANE_HI : LANE_LO);
    if (is_half && addr == ADDR_W'(OFF_CTRL)) begin
      sel = SEL_CTRL;
    end else if (is_half && addr == ADDR_W'(OFF_IDENT)) begin
      sel = SEL_IDENT;
    end else if (is_full || is_half) begin
      if (base == ADDR_W'(OFF_TYPE))       sel = SEL_TYPE;
      else if (base == ADDR_W'(OFF_QBASE)) sel = SEL_QBASE;
      else if (base == ADDR_W'(OFF_WROFF)) sel = SEL_WROFF;
      else if (base == ADDR_W'(OFF_RDOFF)) sel = SEL_RDOFF;
      else if (in_tab)                     sel = SEL_TBASE;
    end
  end
endmodule

// File: rtl/xrb_tbase.sv
module xrb_tbase
  import xrb_pkg::*;
#(
  parameter logic [63:0] RESET_VAL = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  lane_e       lane,
  input  logic [63:0] wdata,
  output logic [63:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (we) q <= tb_merge(q, wdata, lane);
  end
endmodule

// File: rtl/xrb_rdmux.sv
module xrb_rdmux
  import xrb_pkg::*;
#(
  parameter int NTAB = 8,
  parameter logic [31:0] IDENT_VAL = 32'h0,
  parameter logic [63:0] TYPE_VAL  = 64'h0,
  localparam int IDX_W = (NTAB > 1) ? $clog2(NTAB) : 1
) (
  input  sel_e                  sel,
  input  lane_e                 lane,
  input  logic [IDX_W-1:0]      tidx,
  input  logic [31:0]           ctrl,
  input  logic [63:0]           qbase,
  input  logic [63:0]           wroff,
  input  logic [63:0]           rdoff,
  input  logic [NTAB-1:0][63:0] tbase,
  output logic [63:0]           data
);
  logic [63:0] raw;
  logic [63:0] tsel;

  assign tsel = (int'(tidx) < NTAB) ? tbase[tidx] : 64'h0;

  always_comb begin
    case (sel)
      SEL_CTRL:  raw = {32'h0, ctrl};
      SEL_IDENT: raw = {32'h0, IDENT_VAL};
      SEL_TYPE:  raw = TYPE_VAL;
      SEL_QBASE: raw = qbase;
      SEL_WROFF: raw = wroff;
      SEL_RDOFF: raw = rdoff;
      SEL_TBASE: raw = tsel;
      default:   raw = 64'h0;
    endcase
    if (sel == SEL_CTRL || sel == SEL_IDENT || sel == SEL_NONE) data = raw;
    else data = lane_read(raw, lane);
  end
endmodule

// File: rtl/xlat_regbank.sv
module xlat_regbank
  import xrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NTAB   = 8,
  parameter logic [31:0] IDENT_VAL = 32'h5A17_0001,
  parameter logic [63:0] TYPE_VAL  = 64'h0000_0011_2233_4455
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [3:0]          req_size,
  input  logic [63:0]         req_wdata,
  input  logic                sec_dis,
  output logic                rsp_valid,
  output logic [63:0]         rsp_rdata,
  output logic                cfg_en,
  output logic [63:0]         cfg_qbase,
  output logic [63:0]         cfg_wroff,
  output logic [63:0]         cfg_rdoff,
  output logic [NTAB*64-1:0]  cfg_tbase,
  output logic                proc_kick
);
  localparam int IDX_W = (NTAB > 1) ? $clog2(NTAB) : 1;
  localparam logic [31:0] CTRL_RESET = 32'(1) << CTRL_QUIET_BIT;

  sel_e                  sel;
  lane_e                 lane;
  logic [IDX_W-1:0]      tidx;
  logic [31:0]           ctrl_q;
  logic [63:0]           qbase_q, wroff_q, rdoff_q;
  logic [NTAB-1:0][63:0] tb_q;
  logic [63:0]           rd_val;

  // named internal events
  logic        acc_wr, acc_rd, locked;
  logic        ev_wr_ctrl, ev_wr_qbase, ev_wr_wroff, ev_wr_rdoff, ev_wr_tb;
  logic        ev_kick;
  logic [63:0] wroff_next, rdoff_next;

  xrb_decode #(.ADDR_W(ADDR_W), .NTAB(NTAB)) u_dec (
    .addr(req_addr), .size(req_size), .sel(sel), .lane(lane), .tidx(tidx)
  );

  assign locked      = ctrl_q[CTRL_EN_BIT];
  assign acc_wr      = req_valid && req_write;
  assign acc_rd      = req_valid && !req_write;
  assign ev_wr_ctrl  = acc_wr && (sel == SEL_CTRL);
  assign ev_wr_qbase = acc_wr && (sel == SEL_QBASE) && !locked;
  assign ev_wr_wroff = acc_wr && (sel == SEL_WROFF);
  assign ev_wr_rdoff = acc_wr && (sel == SEL_RDOFF) && sec_dis;
  assign ev_wr_tb    = acc_wr && (sel == SEL_TBASE) && !locked;

  assign wroff_next = lane_merge(wroff_q, req_wdata, lane) & ~LOW_FLAG;
  assign rdoff_next = lane_merge(rdoff_q, req_wdata, lane) & ~LOW_FLAG;
  assign ev_kick    = ev_wr_wroff && (lane != LANE_HI) && (wroff_next != rdoff_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RESET;
      qbase_q   <= '0;
      wroff_q   <= '0;
      rdoff_q   <= '0;
      proc_kick <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (ev_wr_ctrl)  ctrl_q  <= ctrl_q | req_wdata[31:0];
      if (ev_wr_qbase) qbase_q <= lane_merge(qbase_q, req_wdata, lane);
      if (ev_wr_qbase)      wroff_q <= '0;
      else if (ev_wr_wroff) wroff_q <= wroff_next;
      if (ev_wr_qbase)      rdoff_q <= '0;
      else if (ev_wr_rdoff) rdoff_q <= rdoff_next;
      proc_kick <= ev_kick;
      rsp_valid <= req_valid;
      rsp_rdata <= acc_rd ? rd_val : 64'h0;
    end
  end

  for (genvar i = 0; i < NTAB; i++) begin : g_tb
    logic we_i;
    assign we_i = ev_wr_tb && (int'(tidx) == i);
    xrb_tbase #(.RESET_VAL(tb_reset(i))) u_tb (
      .clk(clk), .rst_n(rst_n), .we(we_i), .lane(lane),
      .wdata(req_wdata), .q(tb_q[i])
    );
  end

  xrb_rdmux #(.NTAB(NTAB), .IDENT_VAL(IDENT_VAL), .TYPE_VAL(TYPE_VAL)) u_rd (
    .sel(sel), .lane(lane), .tidx(tidx), .ctrl(ctrl_q), .qbase(qbase_q),
    .wroff(wroff_q), .rdoff(rdoff_q), .tbase(tb_q), .data(rd_val)
  );

  assign cfg_en    = locked;
  assign cfg_qbase = qbase_q;
  assign cfg_wroff = wroff_q;
  assign cfg_rdoff = rdoff_q;
  assign cfg_tbase = tb_q;
endmodule

// File: rtl/xlat_regbank_chk.sv
module xlat_regbank_chk #(
  parameter int ADDR_W = 12,
  parameter int NTAB   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [3:0]         req_size,
  input logic               rsp_valid,
  input logic [63:0]        rsp_rdata,
  input logic               cfg_en,
  input logic [63:0]        cfg_qbase,
  input logic [63:0]        cfg_wroff,
  input logic [63:0]        cfg_rdoff,
  input logic [NTAB*64-1:0] cfg_tbase,
  input logic               proc_kick
);
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_en);                                                   // R2
  AST_QBASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(cfg_qbase));                                       // R3
  AST_TBASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(cfg_tbase));                                       // R3
  AST_KICK_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    proc_kick |-> (cfg_wroff != cfg_rdoff));                              // R5
  AST_RETRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wroff[0]);                                                       // R5
  AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdoff[0]);                                                       // R6
  AST_TB0_TYPE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tbase[58:56] == 3'd1 && cfg_tbase[52:48] == 5'd15);               // R7
  AST_BAD_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size != 4'd4 && req_size != 4'd8)
      |=> (rsp_rdata == 64'h0));                                          // R8
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);                                             // R10
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !proc_kick);                             // R10
endmodule

bind xlat_regbank xlat_regbank_chk #(.ADDR_W(ADDR_W), .NTAB(NTAB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .cfg_en(cfg_en), .cfg_qbase(cfg_qbase), .cfg_wroff(cfg_wroff),
  .cfg_rdoff(cfg_rdoff), .cfg_tbase(cfg_tbase), .proc_kick(proc_kick)
);

// File: tb/xlat_regbank_test.sv
module xlat_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, sec_dis = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, cfg_en, proc_kick;
  logic [63:0] rsp_rdata, cfg_qbase, cfg_wroff, cfg_rdoff;
  logic [NTAB*64-1:0] cfg_tbase;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          cd;
    logic [63:0] ed;
    logic        ek;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_regbank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .sec_dis(sec_dis), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_en(cfg_en), .cfg_qbase(cfg_qbase), .cfg_wroff(cfg_wroff),
    .cfg_rdoff(cfg_rdoff), .cfg_tbase(cfg_tbase), .proc_kick(proc_kick)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [11:0] a, input int sz,
                     input logic [63:0] d, input bit sd, input bit cd,
                     input logic [63:0] ed, input logic ek, input string tag);
    item_t it;
    @(negedge clk);
    it.cd = cd; it.ed = ed; it.ek = ek; it.tag = tag;
    sb.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_size = 4'(sz); req_wdata = d; sec_dis = sd;
  endtask

  task automatic rd(input logic [11:0] a, input int sz, input logic [63:0] ed, input string tag);
    bus(1'b0, a, sz, 64'h0, 1'b0, 1'b1, ed, 1'b0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input int sz, input logic [63:0] d,
                    input bit sd, input logic ek, input string tag);
    bus(1'b1, a, sz, d, sd, 1'b0, 64'h0, ek, tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; sec_dis = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: responses are due one cycle after their request (R10)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check("R10 unexpected response", 64'h1, 64'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.cd) check(it.tag, rsp_rdata, it.ed);
        check({it.tag, " kick"}, {63'h0, proc_kick}, {63'h0, it.ek});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfg_en at reset", {63'h0, cfg_en}, 64'h0);
    check("R10 rsp_valid at reset", {63'h0, rsp_valid}, 64'h0);
    // R1 reset values
    rd(12'h000, 4, 64'h8000_0000, "R1 ctrl reset");
    rd(12'h040, 8, 64'h010F_0000_0000_0200, "R1 tbase0 reset");
    rd(12'h04C, 4, 64'h0000_0000_040F_0000, "R1 tbase1 upper half reset");
    rd(12'h050, 8, 64'h0, "R1 tbase2 reset");
    rd(12'h010, 8, 64'h0, "R1 qbase reset");
    // R9 read-only words
    rd(12'h008, 8, 64'h0000_0011_2233_4455, "R9 type read");
    rd(12'h00C, 4, 64'h0000_0000_0000_0011, "R9 type upper half");
    rd(12'h004, 4, 64'h0000_0000_5A17_0001, "R9 ident read");
    wr(12'h008, 8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, "R9 type write");
    wr(12'h004, 4, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, "R9 ident write");
    rd(12'h008, 8, 64'h0000_0011_2233_4455, "R9 type after write");
    rd(12'h004, 4, 64'h0000_0000_5A17_0001, "R9 ident after write");
    // R7 read-only fields and half writes
    wr(12'h040, 8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, "R7 tb0 full write");
    rd(12'h040, 8, 64'hF9EF_FFFF_FFFF_FFFF, "R7 tb0 ro fields kept");
    wr(12'h040, 4, 64'h0000_0000_1234_5678, 1'b0, 1'b0, "R7 tb0 low write");
    wr(12'h044, 4, 64'h0, 1'b0, 1'b0, "R7 tb0 high write");
    rd(12'h040, 8, 64'h010F_0000_1234_5678, "R7 tb0 halves");
    rd(12'h048, 8, 64'h040F_0000_0000_0200, "R7 tb1 untouched");
    // R5 producer offset
    wr(12'h018, 8, 64'h40, 1'b0, 1'b1, "R5 wroff kick");
    rd(12'h018, 8, 64'h40, "R5 wroff value");
    wr(12'h018, 4, 64'h81, 1'b0, 1'b1, "R5 wroff retry masked");
    rd(12'h018, 8, 64'h80, "R5 wroff retry cleared");
    // R6 consumer offset
    wr(12'h020, 8, 64'h81, 1'b1, 1'b0, "R6 rdoff write allowed");
    rd(12'h020, 8, 64'h80, "R6 rdoff stall masked");
    wr(12'h018, 8, 64'h80, 1'b0, 1'b0, "R5 equal offsets no kick");
    wr(12'h01C, 4, 64'h1, 1'b0, 1'b0, "R5 upper half no kick");
    rd(12'h018, 8, 64'h0000_0001_0000_0080, "R5 upper half stored");
    wr(12'h020, 8, 64'h100, 1'b0, 1'b0, "R6 rdoff write blocked");
    rd(12'h020, 8, 64'h80, "R6 rdoff unchanged");
    // R4 queue base clears offsets
    wr(12'h010, 4, 64'hABCD_0000, 1'b0, 1'b0, "R4 qbase low write");
    rd(12'h018, 8, 64'h0, "R4 wroff cleared");
    rd(12'h020, 8, 64'h0, "R4 rdoff cleared");
    rd(12'h010, 8, 64'h0000_0000_ABCD_0000, "R4 qbase value");
    // R8 invalid accesses
    rd(12'h000, 2, 64'h0, "R8 size2 read");
    wr(12'h010, 2, 64'h1111, 1'b0, 1'b0, "R8 size2 write");
    rd(12'h010, 8, 64'h0000_0000_ABCD_0000, "R8 qbase after bad size");
    rd(12'h030, 8, 64'h0, "R8 unmapped read");
    rd(12'h000, 8, 64'h0, "R8 ctrl 8-byte read");
    rd(12'h012, 4, 64'h0, "R8 misaligned read");
    wr(12'h000, 8, 64'h1, 1'b0, 1'b0, "R8 ctrl 8-byte write");
    rd(12'h000, 4, 64'h8000_0000, "R8 ctrl not enabled");
    // R2 enable
    wr(12'h000, 4, 64'h1, 1'b0, 1'b0, "R2 set enable");
    rd(12'h000, 4, 64'h8000_0001, "R2 ctrl or");
    wr(12'h000, 4, 64'h0, 1'b0, 1'b0, "R2 clear attempt");
    rd(12'h000, 4, 64'h8000_0001, "R2 enable sticks");
    // R3 lock
    wr(12'h018, 8, 64'h20, 1'b0, 1'b1, "R3 wroff while enabled");
    wr(12'h010, 8, 64'hFFFF, 1'b0, 1'b0, "R3 qbase write locked");
    rd(12'h010, 8, 64'h0000_0000_ABCD_0000, "R3 qbase unchanged");
    rd(12'h018, 8, 64'h20, "R3 offsets not cleared");
    wr(12'h048, 8, 64'h0, 1'b0, 1'b0, "R3 tb1 write locked");
    rd(12'h048, 8, 64'h040F_0000_0000_0200, "R3 tb1 unchanged");
    idle(3);
    check("R2 cfg_en output", {63'h0, cfg_en}, 64'h1);
    check("R10 all responses seen", 64'(sb.size()), 64'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule